// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block drives a byte-wide parallel NOR flash bus to program single bytes and to erase every block that lies above a protected boot region. A two-bit mode input picks one of three command-set families. Families A and B use a six-cycle unlocked command scheme that differs only in its unlock addresses. Family C uses a command-then-status scheme. For each request the sequencer emits the family's command writes and then polls the device until the operation completes. The result is a code that is zero when the operation succeeds.

A request carries an operation (program or erase), the family, a byte-position flag, a target address and a data byte. The position flag tells the block whether the byte opens, continues or closes a run of writes. The device is put back in read-array mode only when a run closes, when an erase ends, or when an error occurs. Every bus cycle uses the same fixed timing: a one-cycle address setup, a strobe held for a parameter-set number of cycles, and a one-cycle hold.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0, `result` is 00h, and both `flash_we_n` and `flash_oe_n` are 1.
- R2: In every bus cycle, address and write data are driven at least one cycle before the strobe falls. `flash_we_n` stays low for exactly STROBE_CYCLES cycles, and address and data stay stable while a strobe is low. The two strobes are never low together.
- R3: A family A program (mode 0) writes AAh@555h, 55h@2AAh, A0h@555h, then the data byte at the target address. It then reads the target address until bit 7 of the read equals bit 7 of the programmed byte.
- R4: A family B program (mode 1) writes the same values at 5555h, 2AAAh and 5555h. Completion is reached when two consecutive reads of the target address return the same bit 6.
- R5: A family C program (mode 2 or 3) writes 70h at the target and reads it until status bit 7 is 1. It then writes 40h and then the data byte at the target, and again reads until status bit 7 is 1.
- R6: A family A or B erase of one block writes AAh@U1, 55h@U2, 80h@U1, AAh@U1, 55h@U2, then 30h at the block base. Here U1/U2 are 555h/2AAh for A and 5555h/2AAAh for B. It then polls the block base in that family's way, with erased data FFh.
- R7: A family C erase of one block writes 70h at the block base and waits for status bit 7. It then writes 20h and D0h at the block base and waits for status bit 7 again.
- R8: An erase visits blocks BOOT_BLOCKS through the last block in ascending order. The block base is the block number shifted left by BLK_BITS.
- R9: Position flag 01h (last) and 02h (only) end a program with a read-array write at the target: F0h for families A/B, FFh for C. Flag 00h (first) and any other value (middle) issue no such write. An erase always ends with a read-array write at the last block base it handled.
- R10: `result` is 00h on success. A poll that reaches POLL_LIMIT reads without completing ends the operation with 01h, followed by a read-array write.
- R11: For family C, status bits 5:4 nonzero on a completed program or erase poll give result 02h. The block walk stops and a read-array write follows.
- R12: `busy` is 1 from the cycle after a request is accepted until `done`. `done` is a one-cycle pulse with `result` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start request, taken when idle |
| req_erase | input | 1 | 1 = erase all non-boot blocks, 0 = program one byte |
| req_family | input | 2 | Command-set family: 0 = A, 1 = B, 2 or 3 = C |
| req_pos | input | 8 | Byte position flag: 00h first, 01h last, 02h only, else middle |
| req_addr | input | AW | Program target address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | 00h success, 01h timeout, 02h device-reported failure |
| flash_addr | output | AW | Flash address bus |
| flash_dout | output | 8 | Flash write data |
| flash_din | input | 8 | Flash read data |
| flash_we_n | output | 1 | Flash write strobe, active low |
| flash_oe_n | output | 1 | Flash read strobe, active low |

## Verification
The bench drives a flash model that stays busy for a chosen number of reads. It aims at the toggle-bit case where the first array read happens to match the last toggled value. A design that compared against a fixed level, instead of against the previous read, would finish one read early or late. It also uses data bytes whose bit 7 is 0 and 1, so a design that polled for a constant bit 7 would hang or finish too early. It checks flags 00h and 07h, where a stray read-array write would corrupt a multi-byte run, and a poll that never completes, where a miscounted limit shows up as the wrong read total. A family C failure in the first erased block confirms that the walk stops instead of erasing further blocks.

// File: rtl/flash_seq_pkg.sv
// Shared types and the command-step table for the flash sequencer.
// Assumes unlock addresses fit in the address width (at least 15 bits).
package flash_seq_pkg;

    typedef enum logic [1:0] {FAM_A = 2'd0, FAM_B = 2'd1, FAM_C = 2'd2} fam_e;
    typedef enum logic [1:0] {SK_WR = 2'd0, SK_POLL = 2'd1, SK_END = 2'd2} skind_e;
    typedef enum logic [1:0] {AS_UNL1 = 2'd0, AS_UNL2 = 2'd1, AS_TGT = 2'd2} asel_e;
    typedef enum logic [1:0] {PM_DQ7 = 2'd0, PM_DQ6 = 2'd1, PM_SR = 2'd2} pmode_e;

    typedef struct packed {
        skind_e     kind;
        asel_e      asel;
        logic [7:0] val;
        logic       use_data;
        logic       chk;
    } step_t;

    localparam logic [7:0] RES_OK      = 8'h00;
    localparam logic [7:0] RES_TIMEOUT = 8'h01;
    localparam logic [7:0] RES_DEVFAIL = 8'h02;

    // Build one step record.
    function automatic step_t mk(skind_e k, asel_e a, logic [7:0] v, logic ud, logic ck);
        step_t s;
        s.kind = k; s.asel = a; s.val = v; s.use_data = ud; s.chk = ck;
        return s;
    endfunction

    // Step idx of the command sequence for a family and operation.
    function automatic step_t seq_step(fam_e fam, logic erase, logic [2:0] idx);
        step_t s;
        s = mk(SK_END, AS_TGT, 8'h00, 1'b0, 1'b0);
        if (fam == FAM_C) begin
            case (idx)
                3'd0: s = mk(SK_WR,   AS_TGT, 8'h70, 1'b0, 1'b0);
                3'd1: s = mk(SK_POLL, AS_TGT, 8'h00, 1'b0, 1'b0);
                3'd2: s = mk(SK_WR,   AS_TGT, erase ? 8'h20 : 8'h40, 1'b0, 1'b0);
                3'd3: s = mk(SK_WR,   AS_TGT, 8'hD0, !erase, 1'b0);
                3'd4: s = mk(SK_POLL, AS_TGT, 8'h00, 1'b0, 1'b1);
                default: ;
            endcase
        end else if (!erase) begin
            case (idx)
                3'd0: s = mk(SK_WR,   AS_UNL1, 8'hAA, 1'b0, 1'b0);
                3'd1: s = mk(SK_WR,   AS_UNL2, 8'h55, 1'b0, 1'b0);
                3'd2: s = mk(SK_WR,   AS_UNL1, 8'hA0, 1'b0, 1'b0);
                3'd3: s = mk(SK_WR,   AS_TGT,  8'h00, 1'b1, 1'b0);
                3'd4: s = mk(SK_POLL, AS_TGT,  8'h00, 1'b0, 1'b1);
                default: ;
            endcase
        end else begin
            case (idx)
                3'd0: s = mk(SK_WR,   AS_UNL1, 8'hAA, 1'b0, 1'b0);
                3'd1: s = mk(SK_WR,   AS_UNL2, 8'h55, 1'b0, 1'b0);
                3'd2: s = mk(SK_WR,   AS_UNL1, 8'h80, 1'b0, 1'b0);
                3'd3: s = mk(SK_WR,   AS_UNL1, 8'hAA, 1'b0, 1'b0);
                3'd4: s = mk(SK_WR,   AS_UNL2, 8'h55, 1'b0, 1'b0);
                3'd5: s = mk(SK_WR,   AS_TGT,  8'h30, 1'b0, 1'b0);
                3'd6: s = mk(SK_POLL, AS_TGT,  8'h00, 1'b0, 1'b1);
                default: ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
// One flash bus cycle: a setup cycle, a strobe held STROBE_CYCLES cycles, and a hold cycle.
// Assumes start is only raised while idle; read data is sampled on the last strobe cycle.
module flash_bus_cycle #(
    parameter int AW            = 20,
    parameter int STROBE_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_read,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          done,
    output logic [7:0]    rdata,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_dout,
    output logic          bus_we_n,
    output logic          bus_oe_n,
    input  logic [7:0]    bus_din
);
    localparam int CW = $clog2(STROBE_CYCLES + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STRB, PH_HOLD} ph_e;

    ph_e           ph_q;
    logic [CW-1:0] cnt_q;
    logic          rd_q;

    // Phase sequencing and registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_IDLE;
            cnt_q    <= '0;
            rd_q     <= 1'b0;
            bus_addr <= '0;
            bus_dout <= '0;
            bus_we_n <= 1'b1;
            bus_oe_n <= 1'b1;
            rdata    <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    bus_addr <= addr;
                    bus_dout <= wdata;
                    rd_q     <= is_read;
                    ph_q     <= PH_SETUP;
                end
                PH_SETUP: begin
                    bus_we_n <= rd_q;
                    bus_oe_n <= !rd_q;
                    cnt_q    <= '0;
                    ph_q     <= PH_STRB;
                end
                PH_STRB: begin
                    if (cnt_q == CW'(STROBE_CYCLES - 1)) begin
                        bus_we_n <= 1'b1;
                        bus_oe_n <= 1'b1;
                        if (rd_q) rdata <= bus_din;
                        ph_q <= PH_HOLD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign done = (ph_q == PH_HOLD);
endmodule

// File: rtl/flash_poll_judge.sv
// Judges each completion-poll read and counts reads against POLL_LIMIT.
// Assumes clr is pulsed (on any command write) before a new poll begins.
module flash_poll_judge
    import flash_seq_pkg::*;
#(
    parameter int POLL_LIMIT = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       rd_valid,
    input  logic [7:0] rd_data,
    input  pmode_e     mode,
    input  logic       expect7,
    output logic       hit,
    output logic       expired
);
    localparam int CW = $clog2(POLL_LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          prev6_q;
    logic          have_prev_q;

    // Completion test for the current read, by polling method.
    always_comb begin
        case (mode)
            PM_DQ7:  hit = (rd_data[7] == expect7);
            PM_DQ6:  hit = have_prev_q && (rd_data[6] == prev6_q);
            default: hit = rd_data[7];
        endcase
        expired = !hit && (cnt_q == CW'(POLL_LIMIT - 1));
    end

    // Read counter and previous toggle-bit memory.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q       <= '0;
            prev6_q     <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (rd_valid) begin
            cnt_q       <= cnt_q + 1'b1;
            prev6_q     <= rd_data[6];
            have_prev_q <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_prog_seq.sv
// Top of the flash program/erase sequencer: walks the family's step table,
// drives bus cycles, evaluates polls, walks erase blocks and reports a result.
// Assumes AW >= 15 and AW > BLK_BITS; requests arriving while busy are not taken.
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int AW            = 20,
    parameter int BLK_BITS      = 16,
    parameter int BOOT_BLOCKS   = 1,
    parameter int STROBE_CYCLES = 3,
    parameter int POLL_LIMIT    = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_erase,
    input  logic [1:0]    req_family,
    input  logic [7:0]    req_pos,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          busy,
    output logic          done,
    output logic [7:0]    result,
    output logic [AW-1:0] flash_addr,
    output logic [7:0]    flash_dout,
    input  logic [7:0]    flash_din,
    output logic          flash_we_n,
    output logic          flash_oe_n
);
    localparam int BLKW = AW - BLK_BITS;
    localparam logic [BLKW-1:0] FIRST_BLK = BLKW'(BOOT_BLOCKS);
    localparam logic [BLKW-1:0] LAST_BLK  = {BLKW{1'b1}};

    typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE} sq_e;

    sq_e             st_q;
    fam_e            fam_q;
    logic            erase_q;
    logic [7:0]      pos_q;
    logic [AW-1:0]   addr_q;
    logic [7:0]      data_q;
    logic [2:0]      idx_q;
    logic [BLKW-1:0] blk_q;
    logic            final_q;
    logic [7:0]      result_q;

    step_t           cur;
    logic [AW-1:0]   tgt;
    logic            pos_end;
    pmode_e          pmode;
    logic            cyc_start, cyc_read, cyc_done;
    logic [AW-1:0]   cyc_addr;
    logic [7:0]      cyc_data, cyc_rdata;
    logic            rd_valid, p_hit, p_expired;

    // Decode of the current step and derived addresses.
    always_comb begin
        cur     = seq_step(fam_q, erase_q, idx_q);
        tgt     = erase_q ? {blk_q, {BLK_BITS{1'b0}}} : addr_q;
        pos_end = (pos_q == 8'h01) || (pos_q == 8'h02);
        case (fam_q)
            FAM_A:   pmode = PM_DQ7;
            FAM_B:   pmode = PM_DQ6;
            default: pmode = PM_SR;
        endcase
    end

    // Bus cycle request for the step being issued.
    always_comb begin
        cyc_start = 1'b0;
        cyc_read  = 1'b0;
        cyc_addr  = tgt;
        cyc_data  = cur.use_data ? data_q : cur.val;
        if (st_q == SQ_ISSUE) begin
            if (final_q) begin
                cyc_start = 1'b1;
                cyc_data  = (fam_q == FAM_C) ? 8'hFF : 8'hF0;
            end else if (cur.kind == SK_WR) begin
                cyc_start = 1'b1;
                case (cur.asel)
                    AS_UNL1: cyc_addr = (fam_q == FAM_A) ? AW'('h555) : AW'('h5555);
                    AS_UNL2: cyc_addr = (fam_q == FAM_A) ? AW'('h2AA) : AW'('h2AAA);
                    default: cyc_addr = tgt;
                endcase
            end else if (cur.kind == SK_POLL) begin
                cyc_start = 1'b1;
                cyc_read  = 1'b1;
            end
        end
    end

    assign rd_valid = cyc_done && (st_q == SQ_WAIT) && !final_q && (cur.kind == SK_POLL);

    flash_bus_cycle #(.AW(AW), .STROBE_CYCLES(STROBE_CYCLES)) i_bus (
        .clk(clk), .rst_n(rst_n),
        .start(cyc_start), .is_read(cyc_read), .addr(cyc_addr), .wdata(cyc_data),
        .done(cyc_done), .rdata(cyc_rdata),
        .bus_addr(flash_addr), .bus_dout(flash_dout),
        .bus_we_n(flash_we_n), .bus_oe_n(flash_oe_n), .bus_din(flash_din)
    );

    flash_poll_judge #(.POLL_LIMIT(POLL_LIMIT)) i_poll (
        .clk(clk), .rst_n(rst_n),
        .clr(cyc_start && !cyc_read),
        .rd_valid(rd_valid), .rd_data(cyc_rdata),
        .mode(pmode), .expect7(erase_q ? 1'b1 : data_q[7]),
        .hit(p_hit), .expired(p_expired)
    );

    // Operation state machine: accept, step, poll, walk blocks, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SQ_IDLE;
            fam_q    <= FAM_A;
            erase_q  <= 1'b0;
            pos_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            idx_q    <= '0;
            blk_q    <= FIRST_BLK;
            final_q  <= 1'b0;
            result_q <= RES_OK;
        end else begin
            case (st_q)
                SQ_IDLE: if (req_valid) begin
                    fam_q    <= req_family[1] ? FAM_C : (req_family[0] ? FAM_B : FAM_A);
                    erase_q  <= req_erase;
                    pos_q    <= req_pos;
                    addr_q   <= req_addr;
                    data_q   <= req_data;
                    idx_q    <= '0;
                    blk_q    <= FIRST_BLK;
                    final_q  <= 1'b0;
                    result_q <= RES_OK;
                    st_q     <= SQ_ISSUE;
                end
                SQ_ISSUE: begin
                    if (cyc_start) begin
                        st_q <= SQ_WAIT;
                    end else if (erase_q && blk_q != LAST_BLK) begin
                        blk_q <= blk_q + 1'b1;
                        idx_q <= '0;
                    end else if (erase_q || pos_end) begin
                        final_q <= 1'b1;
                    end else begin
                        st_q <= SQ_DONE;
                    end
                end
                SQ_WAIT: if (cyc_done) begin
                    st_q <= SQ_ISSUE;
                    if (final_q) begin
                        st_q <= SQ_DONE;
                    end else if (cur.kind == SK_POLL) begin
                        if (p_hit) begin
                            if (cur.chk && fam_q == FAM_C && cyc_rdata[5:4] != 2'b00) begin
                                result_q <= RES_DEVFAIL;
                                final_q  <= 1'b1;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end else if (p_expired) begin
                            result_q <= RES_TIMEOUT;
                            final_q  <= 1'b1;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy   = (st_q != SQ_IDLE);
    assign done   = (st_q == SQ_DONE);
    assign result = result_q;
endmodule

// File: rtl/flash_prog_seq_chk.sv
// Protocol checker for the flash sequencer, attached by bind.
// Assumes synchronous active-low reset; observes only top-level ports.
module flash_prog_seq_chk #(
    parameter int AW            = 20,
    parameter int STROBE_CYCLES = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [7:0]    result,
    input logic [AW-1:0] flash_addr,
    input logic [7:0]    flash_dout,
    input logic          flash_we_n,
    input logic          flash_oe_n
);
    logic [15:0] we_low_q;

    // Counts consecutive cycles with the write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)          we_low_q <= '0;
        else if (!flash_we_n) we_low_q <= we_low_q + 1'b1;
        else                 we_low_q <= '0;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n)); // R2
    AST_WE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> $stable(flash_addr) && $stable(flash_dout)); // R2
    AST_OE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> $stable(flash_addr)); // R2
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> we_low_q == 16'(STROBE_CYCLES)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> flash_we_n && flash_oe_n); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R12
    AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == 8'h00 || result == 8'h01 || result == 8'h02)); // R10
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.AW(AW), .STROBE_CYCLES(STROBE_CYCLES)) i_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
    .flash_addr(flash_addr), .flash_dout(flash_dout),
    .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
);

// File: tb/test_flash_prog_seq.sv
`timescale 1ns/1ps
module test_flash_prog_seq;
    localparam int AW = 16, BLK_BITS = 13, BOOT = 2, STRB = 3, LIM = 8;
    localparam int NBLK = 1 << (AW - BLK_BITS);

    typedef struct packed {
        logic        erase;
        logic [1:0]  fam;
        logic [7:0]  pos;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  bsy;
        logic [1:0]  fail;
        logic [7:0]  res;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 8'h00, 16'h1234, 8'h5A, 8'd3,  2'd0, 8'h00},
        '{1'b0, 2'd0, 8'h01, 16'h0F00, 8'hA5, 8'd0,  2'd0, 8'h00},
        '{1'b0, 2'd1, 8'h02, 16'h4321, 8'h04, 8'd4,  2'd0, 8'h00},
        '{1'b0, 2'd1, 8'h07, 16'h0001, 8'hFF, 8'd1,  2'd0, 8'h00},
        '{1'b0, 2'd2, 8'h01, 16'h2222, 8'h3C, 8'd2,  2'd0, 8'h00},
        '{1'b0, 2'd2, 8'h00, 16'h3333, 8'h11, 8'd0,  2'd1, 8'h02},
        '{1'b1, 2'd0, 8'h00, 16'h0000, 8'h00, 8'd2,  2'd0, 8'h00},
        '{1'b1, 2'd1, 8'h00, 16'h0000, 8'h00, 8'd1,  2'd0, 8'h00},
        '{1'b1, 2'd2, 8'h00, 16'h0000, 8'h00, 8'd1,  2'd0, 8'h00},
        '{1'b1, 2'd2, 8'h00, 16'h0000, 8'h00, 8'd0,  2'd2, 8'h02},
        '{1'b0, 2'd0, 8'h00, 16'h0ABC, 8'h80, 8'd20, 2'd0, 8'h01},
        '{1'b0, 2'd1, 8'h03, 16'h0DEF, 8'h40, 8'd20, 2'd0, 8'h01}
    };

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_erase = 0;
    logic [1:0] req_family = 0;
    logic [7:0] req_pos = 0, req_data = 0;
    logic [AW-1:0] req_addr = 0;
    logic busy, done;
    logic [7:0] result, flash_dout, flash_din;
    logic [AW-1:0] flash_addr;
    logic flash_we_n, flash_oe_n;

    always #4 clk = ~clk;

    flash_prog_seq #(.AW(AW), .BLK_BITS(BLK_BITS), .BOOT_BLOCKS(BOOT),
                     .STROBE_CYCLES(STRB), .POLL_LIMIT(LIM)) i_flash_prog_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_family(req_family), .req_pos(req_pos), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .done(done), .result(result),
        .flash_addr(flash_addr), .flash_dout(flash_dout), .flash_din(flash_din),
        .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n)
    );

    int n_chk = 0, n_fail = 0;
    bit fin = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Flash device model
    bit log_en = 0;
    int cfg_busy = 0;
    logic [1:0] cfg_fam = 0, cfg_fail = 0, fail_now = 0;
    int mbusy = 0, log_n = 0, rd_n = 0;
    bit pend = 0, mstat = 0, tog = 0;
    logic [7:0] stored = 8'hFF;
    logic [15:0] log_a [256];
    logic [7:0]  log_d [256];

    always @(posedge flash_we_n) if (log_en) begin
        log_a[log_n] = flash_addr; log_d[log_n] = flash_dout; log_n++;
        if (cfg_fam != 2'd2) begin
            if (pend) begin stored = flash_dout; mbusy = cfg_busy; tog = 0; pend = 0; end
            else if (flash_dout == 8'hA0) pend = 1;
            else if (flash_dout == 8'h30) begin stored = 8'hFF; mbusy = cfg_busy; tog = 0; end
        end else begin
            if (pend) begin mbusy = cfg_busy; fail_now = cfg_fail; mstat = 1; pend = 0; end
            else if (flash_dout == 8'h40 || flash_dout == 8'h10) pend = 1;
            else if (flash_dout == 8'hD0) begin mbusy = cfg_busy; fail_now = cfg_fail; mstat = 1; end
            else if (flash_dout == 8'h70) mstat = 1;
            else if (flash_dout == 8'hFF) mstat = 0;
        end
    end

    always @(posedge flash_oe_n) if (log_en) begin
        rd_n++;
        if (mbusy > 0) begin mbusy--; tog = ~tog; end
    end

    always_comb begin
        if (cfg_fam == 2'd2)
            flash_din = mstat ? {mbusy == 0, 1'b0, (mbusy == 0) ? fail_now : 2'b00, 4'b0} : 8'hFF;
        else
            flash_din = (mbusy > 0) ? {~stored[7], tog, 6'b0} : stored;
    end

    // Strobe timing monitor (R2)
    int low_cnt = 0, bad_width = 0, bad_setup = 0, bad_both = 0, n_wr_seen = 0;
    logic prev_we = 1;
    logic [AW-1:0] prev_addr = 0;
    always @(negedge clk) if (rst_n) begin
        if (!flash_we_n) begin
            if (prev_we && flash_addr != prev_addr) bad_setup++;
            low_cnt++;
        end else if (!prev_we) begin
            if (low_cnt != STRB) bad_width++;
            n_wr_seen++;
            low_cnt = 0;
        end
        if (!flash_we_n && !flash_oe_n) bad_both++;
        prev_we = flash_we_n; prev_addr = flash_addr;
    end

    // Expected bus activity, computed from the requirements
    logic [15:0] ex_a [256];
    logic [7:0]  ex_d [256];
    int ex_n, ex_reads;

    task automatic add_w(input logic [15:0] a, input logic [7:0] d);
        ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
    endtask

    function automatic int poll_reads(input logic [1:0] fam, input int k, input logic [7:0] st);
        int par;
        if (fam != 2'd1) return k + 1;
        if (k == 0) return 2;
        par = (k - 1) % 2;
        return (int'(st[6]) == par) ? k + 1 : k + 2;
    endfunction

    task automatic build_exp(input vec_t v);
        logic [15:0] u1, u2, tg;
        logic [7:0] ra;
        bit err;
        int n, k;
        ex_n = 0; ex_reads = 0; err = 0; k = int'(v.bsy); tg = v.addr;
        u1 = (v.fam == 2'd0) ? 16'h0555 : 16'h5555;
        u2 = (v.fam == 2'd0) ? 16'h02AA : 16'h2AAA;
        ra = (v.fam == 2'd2) ? 8'hFF : 8'hF0;
        if (!v.erase) begin
            if (v.fam == 2'd2) begin
                add_w(tg, 8'h70); ex_reads += 1; add_w(tg, 8'h40); add_w(tg, v.data);
            end else begin
                add_w(u1, 8'hAA); add_w(u2, 8'h55); add_w(u1, 8'hA0); add_w(tg, v.data);
            end
            n = poll_reads(v.fam, k, v.data);
            if (n > LIM) begin ex_reads += LIM; err = 1; end
            else begin ex_reads += n; if (v.fam == 2'd2 && v.fail != 0) err = 1; end
            if (err || v.pos == 8'h01 || v.pos == 8'h02) add_w(tg, ra);
        end else begin
            for (int b = BOOT; b < NBLK && !err; b++) begin
                tg = 16'(b << BLK_BITS);
                if (v.fam == 2'd2) begin
                    add_w(tg, 8'h70); ex_reads += 1; add_w(tg, 8'h20); add_w(tg, 8'hD0);
                end else begin
                    add_w(u1, 8'hAA); add_w(u2, 8'h55); add_w(u1, 8'h80);
                    add_w(u1, 8'hAA); add_w(u2, 8'h55); add_w(tg, 8'h30);
                end
                n = poll_reads(v.fam, k, 8'hFF);
                if (n > LIM) begin ex_reads += LIM; err = 1; end
                else begin ex_reads += n; if (v.fam == 2'd2 && v.fail != 0) err = 1; end
            end
            add_w(tg, ra);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        string t;
        if (v.erase) t = (v.fam == 2'd2) ? "R7 R8 R9" : "R6 R8 R9";
        else if (v.fam == 2'd0) t = "R3 R9";
        else if (v.fam == 2'd1) t = "R4 R9";
        else t = "R5 R9";
        if (v.res == 8'h01) t = {t, " R10"};
        if (v.res == 8'h02) t = {t, " R11"};
        return t;
    endfunction

    task automatic run_vec(input vec_t v);
        int cyc, first_bad;
        string t;
        t = tag_of(v);
        cfg_busy = int'(v.bsy); cfg_fail = v.fail; cfg_fam = v.fam;
        mbusy = 0; pend = 0; mstat = 0; fail_now = 0; tog = 0; stored = 8'hFF;
        log_n = 0; rd_n = 0; log_en = 1;
        build_exp(v);
        @(negedge clk);
        req_valid = 1; req_erase = v.erase; req_family = v.fam; req_pos = v.pos;
        req_addr = v.addr; req_data = v.data;
        @(negedge clk);
        req_valid = 0;
        check(busy === 1'b1, "R12", "busy after accept", longint'(busy), 1);
        cyc = 0;
        while (done !== 1'b1 && cyc < 20000) begin @(negedge clk); cyc++; end
        check(done === 1'b1, "R12", "done reached", longint'(done), 1);
        check(result === v.res, {t, " R10"}, "result", longint'(result), longint'(v.res));
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R12", "done one cycle, idle after",
              longint'({done, busy}), 0);
        log_en = 0;
        check(log_n == ex_n, t, "write count", log_n, ex_n);
        first_bad = -1;
        for (int i = 0; i < ex_n && i < log_n; i++)
            if (first_bad < 0 && (log_a[i] !== ex_a[i] || log_d[i] !== ex_d[i])) first_bad = i;
        check(first_bad < 0, t, "write sequence",
              (first_bad < 0) ? 0 : longint'({log_a[first_bad], log_d[first_bad]}),
              (first_bad < 0) ? 0 : longint'({ex_a[first_bad], ex_d[first_bad]}));
        check(rd_n == ex_reads, t, "poll read count", rd_n, ex_reads);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0 && result === 8'h00, "R1", "status after reset",
              longint'({busy, done, result}), 0);
        check(flash_we_n === 1'b1 && flash_oe_n === 1'b1, "R1", "strobes after reset",
              longint'({flash_we_n, flash_oe_n}), 3);
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        // R2 strobe timing over the whole run
        check(n_wr_seen > 0, "R2", "writes observed", n_wr_seen, 1);
        check(bad_width == 0, "R2", "write strobe width errors", bad_width, 0);
        check(bad_setup == 0, "R2", "setup violations", bad_setup, 0);
        check(bad_both == 0, "R2", "both strobes low", bad_both, 0);
        fin = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule